// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the message-signalled interrupt capability of one PCI function. System software reaches it through a plain configuration port. Each access gives a dword address in the 256-byte configuration space, four byte enables and write data. The read data is combinational from the address. The block keeps the control word, the message address, the message data and, when built with per-vector masking, the mask and pending registers. It passes the decoded enable, the enabled vector count, the full address and the data to the interrupt logic of the function.

Three build-time parameters shape the structure: the log2 of the supported vector count, 64-bit address support and per-vector masking. These options set the capability length and where each field sits. A write that lands inside the capability while the function is enabled does two things: it clamps an over-large vector-count request, and it drops pending bits the enabled count no longer covers. The legacy INTx request passes through only while MSI is off. The port is a control path. Its strobes are plain single-cycle pulses with no valid/ready handshake and no back-pressure, so every write takes effect at the clock edge where `cfg_wr` is high.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset, or after a later reset pulse, the enable bit, the enabled-count field, both address words, the data word, the mask and the pending bits are all zero.
- R2: Dword 0 of the capability reads the ID 0x05 in bits 7:0 and zero in bits 15:8. The control word is in bits 31:16. In that word, bit 0 is enable, bits 3:1 are the read-only supported count (log2), bits 6:4 are the enabled count (log2), bit 7 is the 64-bit flag and bit 8 is the masking flag. The other fields lie at dword 1 (address low), then dword 2 (address high, 64-bit builds only), then data, mask and pending in that order.
- R3: Only bits 6:4 and bit 0 of the control word accept writes. Bytes 0, 1 and 3 of dword 0 ignore writes.
- R4: Address bits 1:0 always read zero. The high address word is fully writable and exists only in 64-bit builds.
- R5: The data word holds 16 writable bits. The upper half of its dword reads zero.
- R6: Mask bits below the supported count are writable. All higher mask bits stay zero. Software cannot write the pending register.
- R7: On a write inside the capability that leaves enable set, an enabled-count value above the supported value is replaced by the supported value.
- R8: `pend_set` sets only the pending bits below both the enabled and the supported count. On a write inside the capability that leaves enable set, pending bits at or above the resulting enabled count are cleared.
- R9: `intx_out` follows `intx_req` while enable is clear and is held low while enable is set.
- R10: Accesses outside the capability window change no state and read zero. Bytes past the capability's last byte also read zero.
- R11: A write changes only the bytes whose byte enables are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_addr | input | 6 | Dword address in configuration space |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |
| pend_set | input | 32 | One pulse per vector that fired while masked |
| intx_req | input | 1 | Legacy interrupt request from the function |
| intx_out | output | 1 | Legacy interrupt request after gating |
| msi_en | output | 1 | MSI enable |
| vec_log2 | output | 3 | Enabled vector count, log2 |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data |
| vec_mask | output | 32 | Per-vector mask |
| vec_pend | output | 32 | Per-vector pending bits |

## Verification
Checks run on every cycle. They cover the enabled count never exceeding the supported count while enabled, no pending bit above the enabled count while enabled, address bits 1:0 staying zero, mask bits above the supported count staying zero, and mask and data holding their value when no write targets them. Other behaviour needs the bench's directed scenarios: the register layout on readback, the merging of partial byte enables, the clamp on the write that turns enable on, the trimming after the enabled count shrinks, the gating of `pend_set`, the INTx gating, and accesses just outside the window that have no effect.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam logic [7:0] CAP_ID = 8'h05;

  // Capability length in bytes for the build options.
  function automatic int cap_bytes(bit a64, bit pvm);
    if (pvm) return a64 ? 24 : 20;
    return a64 ? 14 : 10;
  endfunction

  // Bits 0 .. (2**lg - 1) set, the rest clear.
  function automatic logic [31:0] count_mask(logic [2:0] lg);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (i < (1 << lg));
    return m;
  endfunction

  // Merge write data into a word under byte enables and a writable-bit mask.
  function automatic logic [31:0] be_merge(logic [31:0] cur, logic [31:0] wd,
                                           logic [3:0] be, logic [31:0] wm);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = be[b] ? wm[b*8 +: 8] : 8'h00;
    return (cur & ~m) | (wd & m);
  endfunction

endpackage

// File: rtl/msi_win_decode.sv
module msi_win_decode #(
  parameter int CAP_DW = 'h14,
  parameter bit ADDR64 = 1'b1,
  parameter bit PVM    = 1'b1
) (
  input  logic [5:0] addr,
  input  logic [3:0] be,
  output logic       hit_ctrl,
  output logic       hit_alo,
  output logic       hit_ahi,
  output logic       hit_data,
  output logic       hit_mask,
  output logic       hit_pend,
  output logic       be_in_win
);
  import msi_cap_pkg::*;

  localparam int NBYTES   = cap_bytes(ADDR64, PVM);
  localparam int WIN_DW   = (NBYTES + 3) / 4;
  localparam int DATA_REL = ADDR64 ? 3 : 2;
  localparam int MASK_REL = DATA_REL + 1;
  localparam int PEND_REL = DATA_REL + 2;

  logic [5:0] rel;
  logic       in_dw;

  always_comb begin
    rel   = addr - 6'(CAP_DW);
    in_dw = (int'(addr) >= CAP_DW) && (int'(rel) < WIN_DW);
    hit_ctrl = in_dw && rel == 6'd0;
    hit_alo  = in_dw && rel == 6'd1;
    hit_ahi  = in_dw && ADDR64 && rel == 6'd2;
    hit_data = in_dw && rel == 6'(DATA_REL);
    hit_mask = in_dw && PVM && rel == 6'(MASK_REL);
    hit_pend = in_dw && PVM && rel == 6'(PEND_REL);
    be_in_win = 1'b0;
    for (int i = 0; i < 4; i++)
      if (be[i] && in_dw && (int'(rel) * 4 + i) < NBYTES) be_in_win = 1'b1;
  end

endmodule

// File: rtl/msi_ctrl_reg.sv
module msi_ctrl_reg #(
  parameter int VEC_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_byte,
  input  logic [7:0] wbyte,
  input  logic       win_wr,
  output logic       en_q,
  output logic [2:0] mme_q,
  output logic       en_nxt,
  output logic [2:0] mme_nxt
);
  localparam logic [2:0] MMC = 3'(VEC_LOG2);

  always_comb begin
    en_nxt  = wr_byte ? wbyte[0]   : en_q;
    mme_nxt = wr_byte ? wbyte[6:4] : mme_q;
    if (win_wr && en_nxt && mme_nxt > MMC) mme_nxt = MMC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      mme_q <= 3'd0;
    end else begin
      en_q  <= en_nxt;
      mme_q <= mme_nxt;
    end
  end

  p_mme_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (mme_q <= MMC))
    else $error("enabled count above supported count");

endmodule

// File: rtl/msi_msg_regs.sv
module msi_msg_regs #(
  parameter bit ADDR64 = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_alo,
  input  logic        wr_ahi,
  input  logic        wr_data,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] addr_lo,
  output logic [31:0] addr_hi,
  output logic [15:0] data
);
  import msi_cap_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo <= '0;
      data    <= '0;
    end else begin
      if (wr_alo)  addr_lo <= be_merge(addr_lo, wdata, be, 32'hFFFF_FFFC);
      if (wr_data) data    <= be_merge({16'h0, data}, wdata, be, 32'h0000_FFFF)[15:0];
    end
  end

  generate
    if (ADDR64) begin : g_hi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      addr_hi <= '0;
        else if (wr_ahi) addr_hi <= be_merge(addr_hi, wdata, be, 32'hFFFF_FFFF);
      end
    end else begin : g_nohi
      assign addr_hi = '0;
    end
  endgenerate

  p_alo_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_lo[1:0] == 2'b00)
    else $error("address low bits not zero");

  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(data))
    else $error("data changed without write");

endmodule

// File: rtl/msi_vec_regs.sv
module msi_vec_regs #(
  parameter int VEC_LOG2 = 2,
  parameter bit PVM      = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_mask,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic [31:0] pend_set,
  input  logic [2:0]  mme_q,
  input  logic        en_q,
  input  logic        trim,
  input  logic [2:0]  mme_nxt,
  output logic [31:0] mask,
  output logic [31:0] pend
);
  import msi_cap_pkg::*;

  localparam logic [2:0] MMC = 3'(VEC_LOG2);

  generate
    if (PVM) begin : g_pvm
      logic [31:0] cap_m;
      logic [31:0] pend_n;
      always_comb begin
        cap_m  = count_mask(MMC);
        pend_n = pend | (pend_set & cap_m & count_mask(mme_q));
        if (trim) pend_n = pend_n & count_mask(mme_nxt);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mask <= '0;
          pend <= '0;
        end else begin
          if (wr_mask) mask <= be_merge(mask, wdata, be, cap_m);
          pend <= pend_n;
        end
      end

      p_mask_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask & ~count_mask(MMC)) == 32'h0)
        else $error("mask bit above supported count");

      p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask))
        else $error("mask changed without write");

      p_pend_trim_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> ((pend & ~count_mask(mme_q)) == 32'h0))
        else $error("pending bit above enabled count");
    end else begin : g_nopvm
      assign mask = '0;
      assign pend = '0;
    end
  endgenerate

endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs #(
  parameter int CAP_DW   = 'h14,
  parameter int VEC_LOG2 = 2,
  parameter bit ADDR64   = 1'b1,
  parameter bit PVM      = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [5:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] pend_set,
  input  logic        intx_req,
  output logic        intx_out,
  output logic        msi_en,
  output logic [2:0]  vec_log2,
  output logic [63:0] msg_addr,
  output logic [15:0] msg_data,
  output logic [31:0] vec_mask,
  output logic [31:0] vec_pend
);
  import msi_cap_pkg::*;

  localparam logic [2:0] MMC = 3'(VEC_LOG2);

  logic hit_ctrl, hit_alo, hit_ahi, hit_data, hit_mask, hit_pend, be_in_win;
  logic win_wr, en_q, en_nxt;
  logic [2:0] mme_q, mme_nxt;
  logic [31:0] addr_lo, addr_hi;
  logic [15:0] data;
  logic [15:0] ctrl_word;

  msi_win_decode #(.CAP_DW(CAP_DW), .ADDR64(ADDR64), .PVM(PVM)) u_dec (
    .addr(cfg_addr), .be(cfg_be),
    .hit_ctrl(hit_ctrl), .hit_alo(hit_alo), .hit_ahi(hit_ahi),
    .hit_data(hit_data), .hit_mask(hit_mask), .hit_pend(hit_pend),
    .be_in_win(be_in_win)
  );

  assign win_wr = cfg_wr && be_in_win;

  msi_ctrl_reg #(.VEC_LOG2(VEC_LOG2)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_byte(cfg_wr && hit_ctrl && cfg_be[2]), .wbyte(cfg_wdata[23:16]),
    .win_wr(win_wr),
    .en_q(en_q), .mme_q(mme_q), .en_nxt(en_nxt), .mme_nxt(mme_nxt)
  );

  msi_msg_regs #(.ADDR64(ADDR64)) u_msg (
    .clk(clk), .rst_n(rst_n),
    .wr_alo(cfg_wr && hit_alo), .wr_ahi(cfg_wr && hit_ahi),
    .wr_data(cfg_wr && hit_data),
    .be(cfg_be), .wdata(cfg_wdata),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .data(data)
  );

  msi_vec_regs #(.VEC_LOG2(VEC_LOG2), .PVM(PVM)) u_vec (
    .clk(clk), .rst_n(rst_n),
    .wr_mask(cfg_wr && hit_mask), .be(cfg_be), .wdata(cfg_wdata),
    .pend_set(pend_set), .mme_q(mme_q), .en_q(en_q),
    .trim(win_wr && en_nxt), .mme_nxt(mme_nxt),
    .mask(vec_mask), .pend(vec_pend)
  );

  assign ctrl_word = {7'b0, PVM, ADDR64, mme_q, MMC, en_q};

  always_comb begin
    cfg_rdata = 32'h0;
    if (hit_ctrl)      cfg_rdata = {ctrl_word, 8'h00, CAP_ID};
    else if (hit_alo)  cfg_rdata = addr_lo;
    else if (hit_ahi)  cfg_rdata = addr_hi;
    else if (hit_data) cfg_rdata = {16'h0, data};
    else if (hit_mask) cfg_rdata = vec_mask;
    else if (hit_pend) cfg_rdata = vec_pend;
  end

  assign msi_en   = en_q;
  assign vec_log2 = mme_q;
  assign msg_addr = {addr_hi, addr_lo};
  assign msg_data = data;
  assign intx_out = intx_req && !en_q;

endmodule

// File: tb/msi_cap_regs_test.sv
module msi_cap_regs_test;
  localparam int CAP = 'h14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [3:0] cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] pend_set = '0;
  logic intx_req = 1'b0;
  logic intx_out, msi_en;
  logic [2:0] vec_log2;
  logic [63:0] msg_addr;
  logic [15:0] msg_data;
  logic [31:0] vec_mask, vec_pend;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  msi_cap_regs #(.CAP_DW(CAP), .VEC_LOG2(2), .ADDR64(1'b1), .PVM(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pend_set(pend_set), .intx_req(intx_req), .intx_out(intx_out),
    .msi_en(msi_en), .vec_log2(vec_log2), .msg_addr(msg_addr),
    .msg_data(msg_data), .vec_mask(vec_mask), .vec_pend(vec_pend)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_be = be; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic rd_check(string req, logic [5:0] a, logic [31:0] exp);
    cfg_addr = a;
    #1;
    check(req, {32'h0, cfg_rdata}, {32'h0, exp});
  endtask

  task automatic pulse_pend(logic [31:0] v);
    @(negedge clk);
    pend_set = v;
    @(negedge clk);
    pend_set = '0;
  endtask

  task automatic t_reset();
    rd_check("R1 R2 ctrl", 6'(CAP), 32'h0184_0005);
    rd_check("R1 alo", 6'(CAP + 1), 32'h0);
    rd_check("R1 ahi", 6'(CAP + 2), 32'h0);
    rd_check("R1 data", 6'(CAP + 3), 32'h0);
    rd_check("R1 mask", 6'(CAP + 4), 32'h0);
    rd_check("R1 pend", 6'(CAP + 5), 32'h0);
    check("R1 msi_en", {63'h0, msi_en}, 64'h0);
  endtask

  task automatic t_ctrl();
    wr(6'(CAP), 32'hFFFF_FF00, 4'b1110);
    rd_check("R3 R7 enable with clamp", 6'(CAP), 32'h01A5_0005);
    check("R7 vec_log2", {61'h0, vec_log2}, 64'd2);
    wr(6'(CAP), 32'h0000_0000, 4'b0100);
    rd_check("R3 clear", 6'(CAP), 32'h0184_0005);
    wr(6'(CAP), 32'h0070_0000, 4'b0100);
    rd_check("R7 no clamp while disabled", 6'(CAP), 32'h01F4_0005);
    wr(6'(CAP), 32'h0031_0000, 4'b0100);
    rd_check("R7 clamp on enable", 6'(CAP), 32'h01A5_0005);
  endtask

  task automatic t_addr();
    wr(6'(CAP + 1), 32'hFFFF_FFFF, 4'b1111);
    rd_check("R4 low bits zero", 6'(CAP + 1), 32'hFFFF_FFFC);
    wr(6'(CAP + 1), 32'h1234_567B, 4'b0011);
    rd_check("R11 partial bytes", 6'(CAP + 1), 32'hFFFF_5678);
    wr(6'(CAP + 2), 32'hCAFE_0001, 4'b1111);
    rd_check("R4 high word", 6'(CAP + 2), 32'hCAFE_0001);
    check("R4 msg_addr", msg_addr, 64'hCAFE_0001_FFFF_5678);
  endtask

  task automatic t_data();
    wr(6'(CAP + 3), 32'hABCD_1234, 4'b1111);
    rd_check("R5 data readback", 6'(CAP + 3), 32'h0000_1234);
    check("R5 msg_data", {48'h0, msg_data}, 64'h1234);
  endtask

  task automatic t_mask();
    wr(6'(CAP + 4), 32'hFFFF_FFFF, 4'b1111);
    rd_check("R6 mask width", 6'(CAP + 4), 32'h0000_000F);
    wr(6'(CAP + 5), 32'hFFFF_FFFF, 4'b1111);
    rd_check("R6 pending read-only", 6'(CAP + 5), 32'h0);
  endtask

  task automatic t_pend();
    pulse_pend(32'hFFFF_FFFF);
    rd_check("R8 set within count", 6'(CAP + 5), 32'h0000_000F);
    wr(6'(CAP), 32'h0011_0000, 4'b0100);
    rd_check("R8 trim on shrink", 6'(CAP + 5), 32'h0000_0003);
    wr(6'(CAP), 32'h0000_0000, 4'b0100);
    rd_check("R8 no trim when disabled", 6'(CAP + 5), 32'h0000_0003);
    wr(6'(CAP + 5), 32'h0, 4'b1111);
    pulse_pend(32'hFFFF_FFFF);
    rd_check("R8 set gated by count", 6'(CAP + 5), 32'h0000_0003);
    wr(6'(CAP), 32'h0001_0000, 4'b0100);
    rd_check("R8 trim on enable", 6'(CAP + 5), 32'h0000_0001);
  endtask

  task automatic t_outside();
    wr(6'(CAP - 1), 32'hFFFF_FFFF, 4'b1111);
    wr(6'(CAP + 6), 32'hFFFF_FFFF, 4'b1111);
    rd_check("R10 below window", 6'(CAP - 1), 32'h0);
    rd_check("R10 above window", 6'(CAP + 6), 32'h0);
    rd_check("R10 ctrl untouched", 6'(CAP), 32'h0185_0005);
    rd_check("R10 mask untouched", 6'(CAP + 4), 32'h0000_000F);
    rd_check("R10 pend untouched", 6'(CAP + 5), 32'h0000_0001);
  endtask

  task automatic t_intx();
    @(negedge clk);
    intx_req = 1'b1;
    #1;
    check("R9 gated while enabled", {63'h0, intx_out}, 64'h0);
    wr(6'(CAP), 32'h0000_0000, 4'b0100);
    #1;
    check("R9 pass while disabled", {63'h0, intx_out}, 64'h1);
    intx_req = 1'b0;
  endtask

  task automatic t_rerst();
    wr(6'(CAP), 32'h0021_0000, 4'b0100);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    check("R1 msg_addr", msg_addr, 64'h0);
  endtask

  initial begin
    #5000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_addr();
    t_data();
    t_mask();
    t_pend();
    t_outside();
    t_intx();
    t_rerst();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule